// File: doc/BRIEF.md
# Period Timer with Up, Continuous and Up/Down Counting

This block is a 16-bit timer/counter. The count advances on an input tick strobe, and a 2-bit prescaler can thin that strobe by 1, 2, 4 or 8. A period register sets where the count turns around. In up mode the count runs from zero to the period value and starts again at zero. In continuous mode it runs the full 16-bit range. In up/down mode it climbs to the period value and then falls back to zero. A stop mode freezes the count.

Software reaches a control word, the count and the period through a small register port. Writes are synchronous. Reads are combinational.

Two sticky event flags leave the block as interrupt lines. One marks that the count has reached the period value, and the other marks the return to zero. A self-clearing clear bit in the control word resets the count, the prescaler phase and the up/down direction in one write.

Top module: `period_timer`

## Requirements
- R1: After reset the control word, the count, the period and both flags read zero, and the mode is stop.
- R2: Register addresses are 0 for control, 1 for count and 2 for period, and address 3 reads zero. The control read layout is mode in [1:0], prescale in [3:2], compare flag in [5] and wrap flag in [6], with bit 4 always reading zero.
- R3: In up mode (mode 01), each step moves the count up by one until it equals the period value, and the next step gives zero. One period is therefore period+1 steps.
- R4: The compare flag sets on the step that brings the count to the period value.
- R5: The wrap flag sets on the step from the period value to zero in up mode, and on the step from 1 to 0 in up/down mode.
- R6: If the count is above the period value when an up-mode step occurs, the count becomes zero and neither flag is set.
- R7: In continuous mode (mode 10), the count wraps from FFFFh to zero and sets the wrap flag.
- R8: In up/down mode (mode 11), the count climbs to the period value and then descends to zero, after which it climbs again.
- R9: Prescale field value k gives one step per 2^k input ticks.
- R10: Writing control with bit 4 set zeroes the count, restarts the prescaler phase and sets the direction to up. The bit itself reads back zero.
- R11: The flags stay set until a control write carries a zero in the flag's bit position. A control write carrying a one leaves the flag unchanged.
- R12: In stop mode (mode 00), input ticks leave the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cntTick | input | 1 | One-cycle timer input tick |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Write address |
| wrData | input | 16 | Write data |
| rdAddr | input | 2 | Read address |
| rdData | output | 16 | Read data (combinational) |
| irqCmp | output | 1 | Compare flag |
| irqWrap | output | 1 | Wrap flag |

## Verification
The assertions assume that a register write and a timer tick never land in the same cycle. They also assume that the period value does not change while a mode other than stop is counting. The stimulus keeps to these rules: ticks are raised only between write tasks, and every period write takes place in stop mode or in the same sequence that also clears the count. Under these conditions, a count that is frozen, restarted or wrapped can be predicted from the previous cycle alone.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    MODE_STOP = 2'b00,
    MODE_UP   = 2'b01,
    MODE_CONT = 2'b10,
    MODE_UPDN = 2'b11
  } tmrMode_e;

  typedef struct packed {
    logic zero;
    logic load;
    logic inc;
    logic dec;
    logic perLoad;
  } cntStrobe_t;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_CNT  = 2'd1;
  localparam logic [1:0] ADDR_PER  = 2'd2;

  localparam int CTRL_CLR_BIT  = 4;
  localparam int CTRL_CMP_BIT  = 5;
  localparam int CTRL_WRAP_BIT = 6;
  localparam int CTRL_USED_W   = 7;
endpackage

// File: rtl/tmr_dpath.sv
module tmr_dpath
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  cntStrobe_t       strb,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] period
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= '0;
    end else if (strb.zero) begin
      count <= '0;
    end else if (strb.load) begin
      count <= wrData;
    end else if (strb.inc) begin
      count <= count + ONE;
    end else if (strb.dec) begin
      count <= count - ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      period <= '0;
    end else if (strb.perLoad) begin
      period <= wrData;
    end
  end

  // R10: a zero strobe always lands as a zero count
  assert_zero_count_R10: assert property (@(posedge clk) disable iff (!rstN)
    strb.zero |=> count == '0);

  // R2: a software load is visible in the next cycle
  assert_load_count_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load && !strb.zero) |=> count == $past(wrData));
endmodule

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PS_W  = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   cntTick,
  input  logic                   wrEn,
  input  logic [1:0]             wrAddr,
  input  logic [CTRL_USED_W-1:0] ctrlData,
  input  logic [CNT_W-1:0]       count,
  input  logic [CNT_W-1:0]       period,
  output cntStrobe_t             strb,
  output tmrMode_e               modeQ,
  output logic [PS_W-1:0]        psQ,
  output logic                   cmpFlag,
  output logic                   wrapFlag
);
  localparam int DIV_W = (1 << PS_W) - 1;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic             ctrlWr, cntWr, perWr, clrNow;
  logic [DIV_W-1:0] divCnt, divMax;
  logic             divHit, step;
  logic             dirUp, dirFlip;
  logic             stepInc, stepDec, stepZero;
  logic             cmpSet, wrapSet;

  assign ctrlWr = wrEn && (wrAddr == ADDR_CTRL);
  assign cntWr  = wrEn && (wrAddr == ADDR_CNT);
  assign perWr  = wrEn && (wrAddr == ADDR_PER);
  assign clrNow = ctrlWr && ctrlData[CTRL_CLR_BIT];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ <= MODE_STOP;
      psQ   <= '0;
    end else if (ctrlWr) begin
      modeQ <= tmrMode_e'(ctrlData[1:0]);
      psQ   <= ctrlData[2 +: PS_W];
    end
  end

  // prescaler
  always_comb begin
    divMax = DIV_W'(((DIV_W + 1)'(1) << psQ) - (DIV_W + 1)'(1));
  end
  assign divHit = cntTick && (divCnt >= divMax);

  always_ff @(posedge clk) begin
    if (!rstN || clrNow) begin
      divCnt <= '0;
    end else if (cntTick) begin
      divCnt <= divHit ? '0 : divCnt + DIV_W'(1);
    end
  end

  assign step = divHit && !clrNow && !cntWr;

  // step decision
  always_comb begin
    stepInc  = 1'b0;
    stepDec  = 1'b0;
    stepZero = 1'b0;
    dirFlip  = 1'b0;
    unique case (modeQ)
      MODE_STOP: ;
      MODE_UP: begin
        if (count >= period) stepZero = 1'b1;
        else                 stepInc  = 1'b1;
      end
      MODE_CONT: stepInc = 1'b1;
      MODE_UPDN: begin
        if (dirUp) begin
          if (count < period) begin
            stepInc = 1'b1;
          end else if (count != '0) begin
            stepDec = 1'b1;
            dirFlip = 1'b1;
          end
        end else begin
          if (count != '0) begin
            stepDec = 1'b1;
          end else if (period != '0) begin
            stepInc = 1'b1;
            dirFlip = 1'b1;
          end
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN || clrNow) begin
      dirUp <= 1'b1;
    end else if (step && dirFlip) begin
      dirUp <= !dirUp;
    end
  end

  assign cmpSet = step && ((stepInc && (count + ONE == period)) ||
                           (stepZero && (period == '0)));
  assign wrapSet = step && ((modeQ == MODE_UP   && stepZero && count == period) ||
                            (modeQ == MODE_CONT && count == '1) ||
                            (modeQ == MODE_UPDN && stepDec && count == ONE));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmpFlag  <= 1'b0;
      wrapFlag <= 1'b0;
    end else if (ctrlWr) begin
      cmpFlag  <= (cmpFlag  && ctrlData[CTRL_CMP_BIT])  || cmpSet;
      wrapFlag <= (wrapFlag && ctrlData[CTRL_WRAP_BIT]) || wrapSet;
    end else begin
      cmpFlag  <= cmpFlag  || cmpSet;
      wrapFlag <= wrapFlag || wrapSet;
    end
  end

  always_comb begin
    strb.zero    = clrNow || (step && stepZero);
    strb.load    = cntWr;
    strb.inc     = step && stepInc;
    strb.dec     = step && stepDec;
    strb.perLoad = perWr;
  end

  // R12: stop mode without writes freezes the count
  assert_stop_hold_R12: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == MODE_STOP && !wrEn) |=> count == $past(count));

  // R3 / R6: an up-mode step at or past the period lands on zero
  assert_up_restart_R3: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == MODE_UP && divHit && !wrEn && count >= period) |=> count == '0);

  // R7: continuous wrap gives zero and raises the wrap flag
  assert_cont_wrap_R7: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == MODE_CONT && divHit && !wrEn && count == '1) |=> (count == '0 && wrapFlag));

  // R11: flags hold without a control write
  assert_flag_sticky_R11: assert property (@(posedge clk) disable iff (!rstN)
    (wrapFlag && cmpFlag && !ctrlWr) |=> (wrapFlag && cmpFlag));
endmodule

// File: rtl/period_timer.sv
module period_timer
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PS_W  = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cntTick,
  input  logic             wrEn,
  input  logic [1:0]       wrAddr,
  input  logic [CNT_W-1:0] wrData,
  input  logic [1:0]       rdAddr,
  output logic [CNT_W-1:0] rdData,
  output logic             irqCmp,
  output logic             irqWrap
);
  cntStrobe_t       strb;
  tmrMode_e         modeQ;
  logic [PS_W-1:0]  psQ;
  logic [CNT_W-1:0] count, period;
  logic             cmpFlag, wrapFlag;
  logic [CNT_W-1:0] ctrlRead;

  tmr_ctrl #(.CNT_W(CNT_W), .PS_W(PS_W)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .cntTick  (cntTick),
    .wrEn     (wrEn),
    .wrAddr   (wrAddr),
    .ctrlData (wrData[CTRL_USED_W-1:0]),
    .count    (count),
    .period   (period),
    .strb     (strb),
    .modeQ    (modeQ),
    .psQ      (psQ),
    .cmpFlag  (cmpFlag),
    .wrapFlag (wrapFlag)
  );

  tmr_dpath #(.CNT_W(CNT_W)) dpath_i (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .wrData (wrData),
    .count  (count),
    .period (period)
  );

  always_comb begin
    ctrlRead = '0;
    ctrlRead[1:0]         = modeQ;
    ctrlRead[2 +: PS_W]   = psQ;
    ctrlRead[CTRL_CMP_BIT]  = cmpFlag;
    ctrlRead[CTRL_WRAP_BIT] = wrapFlag;
  end

  always_comb begin
    unique case (rdAddr)
      ADDR_CTRL: rdData = ctrlRead;
      ADDR_CNT:  rdData = count;
      ADDR_PER:  rdData = period;
      default:   rdData = '0;
    endcase
  end

  assign irqCmp  = cmpFlag;
  assign irqWrap = wrapFlag;
endmodule

// File: tb/period_timer_tb.sv
module period_timer_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cntTick = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic [1:0]  rdAddr = '0;
  logic [15:0] rdData;
  logic        irqCmp, irqWrap;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  period_timer dut_i (
    .clk(clk), .rstN(rstN), .cntTick(cntTick), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData), .irqCmp(irqCmp), .irqWrap(irqWrap)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    rdAddr = a;
    #1;
    d = rdData;
  endtask

  task automatic tick(input int n);
    @(negedge clk);
    cntTick = 1'b1;
    repeat (n) @(negedge clk);
    cntTick = 1'b0;
  endtask

  task automatic chkCount(input string req, input logic [15:0] exp);
    logic [15:0] v;
    rd(2'd1, v);
    chk(req, v, exp);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    rd(2'd0, v); chk("R1 ctrl", v, 16'h0);
    rd(2'd1, v); chk("R1 count", v, 16'h0);
    rd(2'd2, v); chk("R1 period", v, 16'h0);
    chk("R1 flags", {14'b0, irqCmp, irqWrap}, 16'h0);
  endtask

  task automatic t_regs();
    logic [15:0] v;
    wr(2'd1, 16'h1234); chkCount("R2 count rw", 16'h1234);
    wr(2'd2, 16'hBEEF); rd(2'd2, v); chk("R2 period rw", v, 16'hBEEF);
    rd(2'd3, v); chk("R2 addr3", v, 16'h0);
    wr(2'd0, 16'h001D); rd(2'd0, v); chk("R2 ctrl layout / R10 clr reads 0", v, 16'h000D);
    chkCount("R10 clear zeroes count", 16'h0);
  endtask

  task automatic t_up();
    logic [15:0] v;
    wr(2'd0, 16'h0010); wr(2'd2, 16'd4); wr(2'd0, 16'h0001);
    for (int i = 1; i <= 3; i++) begin
      tick(1); chkCount("R3 up step", 16'(i));
      chk("R4 cmp early", {15'b0, irqCmp}, 16'h0);
    end
    tick(1); chkCount("R3 up top", 16'd4);
    chk("R4 cmp at period", {15'b0, irqCmp}, 16'h1);
    chk("R5 wrap not yet", {15'b0, irqWrap}, 16'h0);
    tick(1); chkCount("R3 restart", 16'd0);
    chk("R5 wrap up", {15'b0, irqWrap}, 16'h1);
    wr(2'd0, 16'h0021); rd(2'd0, v);
    chk("R11 write1 keeps, write0 clears", v & 16'h0060, 16'h0020);
    tick(2); chk("R11 sticky", {15'b0, irqCmp}, 16'h1);
    wr(2'd0, 16'h0001); rd(2'd0, v); chk("R11 cleared", v & 16'h0060, 16'h0);
  endtask

  task automatic t_above();
    wr(2'd0, 16'h0010); wr(2'd2, 16'd10); wr(2'd1, 16'd100); wr(2'd0, 16'h0001);
    tick(1); chkCount("R6 above restart", 16'd0);
    chk("R6 no flags", {14'b0, irqCmp, irqWrap}, 16'h0);
  endtask

  task automatic t_cont();
    wr(2'd0, 16'h0010); wr(2'd2, 16'd3); wr(2'd1, 16'hFFFE); wr(2'd0, 16'h0002);
    tick(1); chkCount("R7 cont", 16'hFFFF);
    chk("R7 no wrap yet", {15'b0, irqWrap}, 16'h0);
    tick(1); chkCount("R7 wrap to 0", 16'h0);
    chk("R7 wrap flag", {15'b0, irqWrap}, 16'h1);
    tick(3); chkCount("R7 cont run", 16'd3);
    chk("R4 cmp in cont", {15'b0, irqCmp}, 16'h1);
  endtask

  task automatic t_updn();
    int seq[7] = '{1, 2, 3, 2, 1, 0, 1};
    wr(2'd0, 16'h0010); wr(2'd2, 16'd3); wr(2'd0, 16'h0013);
    for (int i = 0; i < 7; i++) begin
      tick(1); chkCount("R8 updown seq", 16'(seq[i]));
      if (i == 1) chk("R4 updown cmp early", {15'b0, irqCmp}, 16'h0);
      if (i == 2) chk("R4 updown cmp", {15'b0, irqCmp}, 16'h1);
      if (i == 4) chk("R5 updown wrap early", {15'b0, irqWrap}, 16'h0);
      if (i == 5) chk("R5 updown wrap", {15'b0, irqWrap}, 16'h1);
    end
  endtask

  task automatic t_presc();
    wr(2'd0, 16'h0010); wr(2'd2, 16'd100); wr(2'd0, 16'h001D);
    tick(7); chkCount("R9 div8 partial", 16'd0);
    tick(1); chkCount("R9 div8 one", 16'd1);
    tick(8); chkCount("R9 div8 two", 16'd2);
  endtask

  task automatic t_clear();
    wr(2'd0, 16'h0019);
    tick(2); chkCount("R10 div4 partial", 16'd0);
    wr(2'd0, 16'h0019);
    tick(3); chkCount("R10 divider restarted", 16'd0);
    tick(1); chkCount("R10 divider step", 16'd1);
    wr(2'd0, 16'h0010); wr(2'd2, 16'd3); wr(2'd0, 16'h0013);
    tick(4); chkCount("R8 descending", 16'd2);
    wr(2'd0, 16'h0013); chkCount("R10 clear count", 16'd0);
    wr(2'd1, 16'd1);
    tick(1); chkCount("R10 direction up", 16'd2);
  endtask

  task automatic t_stop();
    wr(2'd0, 16'h0010); wr(2'd1, 16'd5);
    tick(10); chkCount("R12 stop holds", 16'd5);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_up();
    t_above();
    t_cont();
    t_updn();
    t_presc();
    t_clear();
    t_stop();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule